// File: doc/BRIEF.md
# Operand Issue and Write-Back Path with Result Forwarding

This block is the issue end and the write-back end of a short in-order integer pipeline that only executes register-to-register adds. An instruction names two source registers and one destination register. At issue the block fetches both operands, either from its register bank or from the result crossbar, and sends them into a two-stage adder. The low half of the sum is formed in the first execute stage and the high half, with the carry, in the second. The finished sum then spends one cycle on the result crossbar and is written into the bank at the end of that cycle.

A small tag per register records which in-flight stage will produce that register's newest value, if any. A source whose producer is still inside the adder holds the instruction at issue by dropping `in_ready`. A source whose producer sits on the crossbar is served from the crossbar. Because the bank write completes at the edge that ends the crossbar cycle, an instruction issued one cycle later reads the new value from the bank and never sees the stale one. The crossbar register is also visible at the ports, so every result can be observed as it is written back.

Top module: `issue_bypass`

## Requirements
- R1: On reset `wb_valid` is 0, `in_ready` is 1, and register i of the bank (i = 0..7) holds (i+1) * 0x9E3779B97F4A7C15, truncated to 64 bits. Register 0 is an ordinary writable register.
- R2: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result is shown on `wb_valid`/`wb_dst`/`wb_data` after the third rising edge that counts the acceptance edge as the first, and is held there for exactly one cycle.
- R3: The result is the 64-bit sum of the two source values, modulo 2^64, with the carry carried across the whole width.
- R4: `in_ready` is 0 exactly when a source register equals the destination of an instruction accepted on one of the previous two rising edges. An instruction held this way is not sent.
- R5: A source whose newest producer was accepted exactly three edges earlier, so that the producer is on the result crossbar, takes that result and not the bank value.
- R6: An instruction accepted four edges after its producer, which is one cycle after the producer has left the crossbar, reads the new value from the bank.
- R7: When several in-flight instructions target the same register, a later reader gets the value of the youngest of them.
- R8: When both sources name the same register, both operands get the same correct value, including when that value is forwarded.
- R9: Write-backs appear in acceptance order, each with the destination of its own instruction.
- R10: A cycle with `in_valid` at 0 sends nothing, so no write-back appears three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered at issue |
| in_ready | output | 1 | Issue can take the offered instruction this cycle |
| in_src_a | input | 3 | First source register number |
| in_src_b | input | 3 | Second source register number |
| in_dst | input | 3 | Destination register number |
| wb_valid | output | 1 | A result is on the crossbar and is written this cycle |
| wb_dst | output | 3 | Destination of the result on the crossbar |
| wb_data | output | 64 | Result on the crossbar |

## Verification
`in_ready` is combinational, so the bench sets an instruction just after a falling edge and reads `in_ready` one time step later in the same half cycle. It compares that value with a stall prediction made from the destinations it accepted on the previous two edges. A result accepted on the edge after falling edge n is due on the write-back ports at falling edge n+3: two stage registers and the crossbar register lie in between. The bench queues each expected write-back with that due cycle and insists that the write-back ports are idle on every other cycle. Expected sums come from a sequential register model in the bench. Each check is labelled by how far back the operand's producer was accepted: three edges back is the forwarding case and four edges back is the one-cycle-late case.

// File: rtl/issue_bypass.sv
module issue_bypass #(
  parameter int DATA_W = 64,
  parameter int NREG = 8,
  parameter logic [DATA_W-1:0] INIT_STEP = 64'h9E37_79B9_7F4A_7C15,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_src_a,
  input  logic [AW-1:0]     in_src_b,
  input  logic [AW-1:0]     in_dst,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_dst,
  output logic [DATA_W-1:0] wb_data
);
  localparam int HALF = DATA_W / 2;
  localparam logic [1:0] T_IDLE = 2'd0, T_E1 = 2'd1, T_E2 = 2'd2, T_XB = 2'd3;

  logic [1:0]        tag  [NREG];
  logic [DATA_W-1:0] bank [NREG];

  logic              e1_v;
  logic [AW-1:0]     e1_dst;
  logic [DATA_W-1:0] e1_a, e1_b;

  logic              e2_v, e2_c;
  logic [AW-1:0]     e2_dst;
  logic [HALF-1:0]   e2_lo, e2_ahi, e2_bhi;

  logic              xb_v;
  logic [AW-1:0]     xb_dst;
  logic [DATA_W-1:0] xb_data;

  logic [1:0] tag_a, tag_b;
  logic       issue;
  logic [DATA_W-1:0] op_a, op_b;
  logic [HALF:0]     lo_sum;
  logic [HALF-1:0]   hi_sum;

  assign tag_a = tag[in_src_a];
  assign tag_b = tag[in_src_b];
  assign in_ready = !(tag_a == T_E1 || tag_a == T_E2 || tag_b == T_E1 || tag_b == T_E2);
  assign issue = in_valid && in_ready;
  assign op_a = (tag_a == T_XB) ? xb_data : bank[in_src_a];
  assign op_b = (tag_b == T_XB) ? xb_data : bank[in_src_b];
  assign lo_sum = {1'b0, e1_a[HALF-1:0]} + {1'b0, e1_b[HALF-1:0]};
  assign hi_sum = e2_ahi + e2_bhi + {{(HALF-1){1'b0}}, e2_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) tag[i] <= T_IDLE;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (issue && in_dst == AW'(i)) tag[i] <= T_E1;
        else begin
          case (tag[i])
            T_E1:    tag[i] <= T_E2;
            T_E2:    tag[i] <= T_XB;
            default: tag[i] <= T_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_v <= 1'b0; e1_dst <= '0; e1_a <= '0; e1_b <= '0;
    end else begin
      e1_v <= issue;
      if (issue) begin
        e1_dst <= in_dst;
        e1_a   <= op_a;
        e1_b   <= op_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e2_v <= 1'b0; e2_c <= 1'b0; e2_dst <= '0;
      e2_lo <= '0; e2_ahi <= '0; e2_bhi <= '0;
    end else begin
      e2_v <= e1_v;
      if (e1_v) begin
        e2_dst <= e1_dst;
        e2_lo  <= lo_sum[HALF-1:0];
        e2_c   <= lo_sum[HALF];
        e2_ahi <= e1_a[DATA_W-1:HALF];
        e2_bhi <= e1_b[DATA_W-1:HALF];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xb_v <= 1'b0; xb_dst <= '0; xb_data <= '0;
    end else begin
      xb_v <= e2_v;
      if (e2_v) begin
        xb_dst  <= e2_dst;
        xb_data <= {hi_sum, e2_lo};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= INIT_STEP * DATA_W'(i + 1);
    end else if (xb_v) begin
      bank[xb_dst] <= xb_data;
    end
  end

  assign wb_valid = xb_v;
  assign wb_dst   = xb_dst;
  assign wb_data  = xb_data;

  for (genvar r = 0; r < NREG; r++) begin : g_tag_chk
    p_tag_e1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tag[r] == T_E1 |-> e1_v && e1_dst == AW'(r));
    p_tag_e2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tag[r] == T_E2 |-> e2_v && e2_dst == AW'(r));
    p_tag_xb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tag[r] == T_XB |-> xb_v && xb_dst == AW'(r));
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !e1_v);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !e1_v);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xb_v |-> $past(e1_v, 2) && $past(e1_dst, 2) == xb_dst);
  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xb_v |-> xb_data == $past(e1_a, 2) + $past(e1_b, 2));
  p_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && tag_a == T_XB) |=> e1_a == $past(xb_data));
  p_bank_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xb_v |=> bank[$past(xb_dst)] == $past(xb_data));
endmodule

// File: tb/sim_issue_bypass.sv
module sim_issue_bypass;
  localparam logic [63:0] STEP = 64'h9E37_79B9_7F4A_7C15;
  localparam int NDIR = 16;
  localparam int NRND = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic wb_valid;
  logic [2:0] wb_dst;
  logic [63:0] wb_data;

  issue_bypass u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data));

  always #10 clk = ~clk;

  typedef struct { int due; logic [2:0] dst; logic [63:0] data; string req; } exp_t;
  exp_t q[$];
  logic [63:0] mreg [8];
  int lastw [8];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [8:0] dir_instr(int k);
    case (k)
      0: return {3'd1, 3'd2, 3'd3};
      1: return {3'd4, 3'd1, 3'd1};
      2: return {3'd5, 3'd2, 3'd6};
      3: return {3'd0, 3'd7, 3'd7};
      4: return {3'd7, 3'd5, 3'd3};
      5: return {3'd2, 3'd3, 3'd3};
      6: return {3'd6, 3'd0, 3'd0};
      7: return {3'd3, 3'd4, 3'd4};
      8: return {3'd5, 3'd1, 3'd2};
      9: return {3'd0, 3'd7, 3'd7};
      10: return {3'd6, 3'd4, 3'd4};
      11: return {3'd3, 3'd1, 3'd1};
      12: return {3'd7, 3'd5, 3'd5};
      13: return {3'd1, 3'd2, 3'd2};
      14: return {3'd1, 3'd3, 3'd3};
      default: return {3'd4, 3'd1, 3'd0};
    endcase
  endfunction

  function automatic string pick_req(int k, logic [2:0] a, logic [2:0] b, int cyc);
    int da, db;
    da = cyc - lastw[a];
    db = cyc - lastw[b];
    if (k == 0) return "R1";
    if (k == NDIR - 1) return "R7";
    if (a == b && da == 3) return "R8";
    if (da == 3 || db == 3) return "R5";
    if (da == 4 || db == 4) return "R6";
    return "R3";
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc = 0, k = 0;
    bit holding = 0, h1_v = 0, h2_v = 0, exp_rdy, acc;
    logic [2:0] h1_d = '0, h2_d = '0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      mreg[i] = STEP * 64'(i + 1);
      lastw[i] = -100;
    end
    repeat (3) @(negedge clk);
    check(wb_valid == 1'b0, "R1", "wb_valid in reset", 64'(wb_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wb_valid == 1'b0, "R1", "wb_valid after reset", 64'(wb_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    while (k < NDIR + NRND || holding || q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (q.size() > 0 && q[0].due == cyc) begin
        check(wb_valid == 1'b1, "R2", "wb_valid on due cycle", 64'(wb_valid), 64'd1);
        check(wb_dst == q[0].dst, "R9", "wb_dst", 64'(wb_dst), 64'(q[0].dst));
        check(wb_data == q[0].data, q[0].req, "wb_data", wb_data, q[0].data);
        void'(q.pop_front());
      end else begin
        check(wb_valid == 1'b0, "R10", "wb_valid with nothing due", 64'(wb_valid), 64'd0);
      end
      if (!holding) begin
        if (k < NDIR) begin
          {in_dst, in_src_a, in_src_b} = dir_instr(k);
          in_valid = 1'b1;
        end else if (k < NDIR + NRND) begin
          in_valid = ($urandom_range(0, 9) < 8);
          in_dst = 3'($urandom_range(0, 7));
          in_src_a = 3'($urandom_range(0, 7));
          in_src_b = 3'($urandom_range(0, 7));
        end else begin
          in_valid = 1'b0;
        end
        if (k < NDIR + NRND) k++;
      end
      #1;
      exp_rdy = !((h1_v && (in_src_a == h1_d || in_src_b == h1_d)) ||
                  (h2_v && (in_src_a == h2_d || in_src_b == h2_d)));
      if (in_valid)
        check(in_ready == exp_rdy, "R4", "in_ready", 64'(in_ready), 64'(exp_rdy));
      acc = in_valid && exp_rdy;
      if (acc) begin
        exp_t e;
        e.due = cyc + 3;
        e.dst = in_dst;
        e.data = mreg[in_src_a] + mreg[in_src_b];
        e.req = pick_req(k - 1, in_src_a, in_src_b, cyc);
        q.push_back(e);
        mreg[in_dst] = e.data;
        lastw[in_dst] = cyc;
        holding = 0;
      end else begin
        holding = in_valid;
      end
      h2_v = h1_v; h2_d = h1_d;
      h1_v = acc;  h1_d = in_dst;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule